// File: doc/BRIEF.md
# Card Command Launcher with Response Capture

This block sends one command at a time to a memory card and captures what comes back. Software writes a 6-bit command index and a 32-bit argument. The argument is written as two 16-bit halves. It then writes a control word. If the card clock is running and the hold bit of the control word is clear, that write launches the command straight away. Otherwise the command stays pending until a clock-start pulse releases it. The launched index and argument are latched and offered to a card model on a valid/ready request channel.

The card returns a response on a valid/ready channel. The response carries a length in bytes (0 to 16) and up to 16 bytes. The block compares the length with the minimum that the selected response type needs. It then either declares a response timeout, or packs the bytes into a nine-entry halfword FIFO and reports completion. On completion it signals the data engine when the control word asks for a data phase. Each accepted response produces an end-of-command pulse for the interrupt block.

Back-pressure rules: `card_req_valid` stays high with a stable index and argument until `card_req_ready` is seen. The one exception is a control-word write, which withdraws the request and may replace it. `card_rsp_ready` is high while a response is awaited, and also while responses of withdrawn commands are still owed. Those late responses are accepted and discarded.

Top module: `cmd_issue_unit`

## Requirements
- R1: The command-index register (address 1) keeps the low 6 bits of a write. It reads back with bit 6 forced to one and all higher bits zero.
- R2: A write to address 2 replaces argument bits 31:16, and a write to address 3 replaces bits 15:0. Each address reads back its own half, and the other half is left unchanged.
- R3: A write to the control register (address 0) does four things:
  - It stores the value masked with 0x3dff, and that value reads back.
  - It pulses `evt_abort` in the next cycle.
  - It marks a command pending.
  - If `clk_on` is high and bit 10 of the written value is clear, it launches the command at once.
- R4: A `clk_start` pulse launches a pending command when control bit 10 is clear. A `clk_start` pulse with no pending command, or with bit 10 set, has no effect.
- R5: A launch does the following:
  - It pulses `evt_launch`, clears the pending flag and both status bits, and zeroes all FIFO entries.
  - It presents the index and argument held at that moment on the request channel.
  - The request stays valid and stable until it is accepted, and `cmd_busy` is high until the response is taken.
- R6: Control bits 1:0 select the response type, which sets the minimum response length: type 0 needs 0 bytes, types 1 and 3 need 4 bytes, and type 2 needs 16 bytes. A shorter response sets `stat_resp_tout` and leaves the FIFO zeroed.
- R7: Every response accepted for the current command pulses `evt_end_cmd` in the cycle after acceptance. This holds for both a completion and a timeout.
- R8: On completion, halfword i of the FIFO holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte k sits at bits 8k+7:8k of `card_rsp_data`. Bytes at or beyond the returned length read as zero, and entry 8 is always zero.
- R9: Each read of address 4 returns the next FIFO halfword. After all nine entries have been read, it returns zero. Completion resets the read position to entry 0, while a timeout leaves the read position unchanged.
- R10: On completion, `stat_resp_done` is set. `evt_data_start` pulses together with `evt_end_cmd` only when control bit 2 is set.
- R11: A control write while a command is in flight withdraws it. The response of a withdrawn command is accepted and discarded, with no `evt_end_cmd`, no status change and no FIFO change.
- R12: After reset, all registers read zero except bit 6 of address 1, all pulses and status bits are low, and no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the response FIFO at address 4) |
| reg_addr | input | 3 | Register address: 0 control, 1 index, 2 argument high, 3 argument low, 4 response |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, combinational |
| clk_on | input | 1 | Card clock currently running |
| clk_start | input | 1 | Clock-start pulse that releases a pending command |
| card_req_valid | output | 1 | Command request valid |
| card_req_ready | input | 1 | Card accepts the request |
| card_req_index | output | 6 | Latched command index |
| card_req_arg | output | 32 | Latched command argument |
| card_rsp_valid | input | 1 | Card response valid |
| card_rsp_ready | output | 1 | Block accepts a response |
| card_rsp_len | input | 5 | Response length in bytes, 0 to 16 |
| card_rsp_data | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| evt_launch | output | 1 | Pulse: command launched, data rings to be emptied |
| evt_abort | output | 1 | Pulse: control write cancelled any transfer |
| evt_end_cmd | output | 1 | Pulse: response handled (complete or timeout) |
| evt_data_start | output | 1 | Pulse: data phase begins |
| stat_resp_tout | output | 1 | Response timeout status |
| stat_resp_done | output | 1 | Response completed status |
| cmd_busy | output | 1 | Command request or response wait in progress |

## Verification
The riskiest hidden state is the count of owed responses from withdrawn commands. If it is off by one, the next real response is either dropped or credited to the wrong command. That error shows at the ports as a missing or misplaced `evt_end_cmd` and a wrong `card_rsp_ready` within one cycle of the card's reply. A stale pending flag shows up as a launch on a `clk_start` pulse that should have done nothing. A wrong FIFO read position shows up on the very next read of address 4. Because the bench model tracks each of these separately every cycle, a divergence is reported in the cycle it first reaches a pin.

// File: rtl/cmd_issue_pkg.sv
`timescale 1ns/1ps
package cmd_issue_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int DATA_W    = 16;
  localparam int CTRL_W    = 14;
  localparam int RSP_BYTES = 16;
  localparam int RSP_WORDS = 9;
  localparam int LEN_W     = $clog2(RSP_BYTES + 1);
  localparam int ADDR_W    = 3;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 14'h3dff;
  localparam int DATA_EN_BIT = 2;
  localparam int HOLD_BIT    = 10;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_IDX  = 3'd1,
    RA_ARGH = 3'd2,
    RA_ARGL = 3'd3,
    RA_RESP = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  function automatic logic [LEN_W-1:0] rsp_min_len(input logic [1:0] rtype);
    case (rtype)
      2'd0:    rsp_min_len = LEN_W'(0);
      2'd2:    rsp_min_len = LEN_W'(16);
      default: rsp_min_len = LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/cmd_regs.sv
`timescale 1ns/1ps
module cmd_regs
  import cmd_issue_pkg::*;
#(
  parameter int P_IDX_W  = IDX_W,
  parameter int P_ARG_W  = ARG_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_CTRL_W = CTRL_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_IDX_W-1:0]  idx,
  output logic [P_ARG_W-1:0]  arg,
  output logic [P_CTRL_W-1:0] ctrl,
  output logic                ctrl_wr,
  output logic [P_CTRL_W-1:0] ctrl_new
);
  localparam int HALF_W = P_ARG_W / 2;

  assign ctrl_wr  = wr && (addr == P_ADDR_W'(RA_CTRL));
  assign ctrl_new = wdata[P_CTRL_W-1:0] & CTRL_KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      ctrl <= '0;
    end else begin
      if (wr && addr == P_ADDR_W'(RA_IDX)) idx <= wdata[P_IDX_W-1:0];
      if (ctrl_wr) ctrl <= ctrl_new;
    end
  end

  // one register per argument half; half 0 sits at the low-argument address
  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      localparam logic [P_ADDR_W-1:0] HA = P_ADDR_W'(RA_ARGL) - P_ADDR_W'(h);
      logic [HALF_W-1:0] half_q;
      always_ff @(posedge clk) begin
        if (!rst_n) half_q <= '0;
        else if (wr && addr == HA) half_q <= wdata[HALF_W-1:0];
      end
      assign arg[h*HALF_W +: HALF_W] = half_q;
    end
  endgenerate
endmodule

// File: rtl/resp_fifo.sv
`timescale 1ns/1ps
module resp_fifo
  import cmd_issue_pkg::*;
#(
  parameter int P_WORDS = RSP_WORDS,
  parameter int P_BYTES = RSP_BYTES,
  parameter int P_LEN_W = LEN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [P_LEN_W-1:0]   load_len,
  input  logic [P_BYTES*8-1:0] load_data,
  input  logic                 pop,
  output logic [15:0]          head
);
  localparam int PTR_W = $clog2(P_WORDS + 1);

  logic [PTR_W-1:0] rptr_q;
  logic [15:0]      mem_q [P_WORDS];

  genvar i, b;
  generate
    for (i = 0; i < P_WORDS; i++) begin : g_word
      logic [15:0] packed_w;
      for (b = 0; b < 2; b++) begin : g_byte
        localparam int K = 2 * i + b;
        if (K < P_BYTES) begin : g_live
          assign packed_w[8*b +: 8] =
            (load_len > P_LEN_W'(K)) ? load_data[8*K +: 8] : 8'h00;
        end else begin : g_pad
          assign packed_w[8*b +: 8] = 8'h00;
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n || clr) mem_q[i] <= '0;
        else if (load)     mem_q[i] <= packed_w;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                 rptr_q <= '0;
    else if (load)                              rptr_q <= '0;
    else if (pop && rptr_q < PTR_W'(P_WORDS))   rptr_q <= rptr_q + PTR_W'(1);
  end

  always_comb begin
    head = '0;
    for (int n = 0; n < P_WORDS; n++)
      if (rptr_q == PTR_W'(n)) head = mem_q[n];
  end
endmodule

// File: rtl/cmd_seq.sv
`timescale 1ns/1ps
module cmd_seq
  import cmd_issue_pkg::*;
#(
  parameter int P_IDX_W   = IDX_W,
  parameter int P_ARG_W   = ARG_W,
  parameter int P_LEN_W   = LEN_W,
  parameter int P_STALE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic                 new_hold,
  input  logic                 cur_hold,
  input  logic                 cur_data_en,
  input  logic [1:0]           cur_rtype,
  input  logic                 clk_on,
  input  logic                 clk_start,
  input  logic [P_IDX_W-1:0]   idx,
  input  logic [P_ARG_W-1:0]   arg,
  input  logic                 req_ready,
  input  logic                 rsp_valid,
  input  logic [P_LEN_W-1:0]   rsp_len,
  output logic                 req_valid,
  output logic [P_IDX_W-1:0]   req_index,
  output logic [P_ARG_W-1:0]   req_arg,
  output logic                 rsp_ready,
  output logic                 launch,
  output logic                 resp_ok,
  output logic                 evt_launch,
  output logic                 evt_abort,
  output logic                 evt_end_cmd,
  output logic                 evt_data_start,
  output logic                 stat_tout,
  output logic                 stat_done,
  output logic                 busy
);
  seq_state_e state_q, state_d;
  logic [P_STALE_W-1:0] owed_q;
  logic pend_q;
  logic own_hs, drop_hs, req_hs, orphan, resp_bad;

  assign req_valid = (state_q == SQ_ISSUE);
  assign rsp_ready = (state_q == SQ_WAIT) || (owed_q != '0);
  assign busy      = (state_q != SQ_IDLE);

  assign req_hs  = req_valid && req_ready;
  assign drop_hs = rsp_valid && (owed_q != '0);
  assign own_hs  = rsp_valid && (state_q == SQ_WAIT) && (owed_q == '0);
  // a control write leaves one response owed if the card already holds the request
  assign orphan  = ctrl_wr && (((state_q == SQ_WAIT) && !own_hs) ||
                               ((state_q == SQ_ISSUE) && req_hs));

  assign launch   = ctrl_wr ? (clk_on && !new_hold)
                            : (clk_start && pend_q && !cur_hold);
  assign resp_ok  = own_hs && !ctrl_wr && (rsp_len >= rsp_min_len(cur_rtype));
  assign resp_bad = own_hs && !ctrl_wr && !(rsp_len >= rsp_min_len(cur_rtype));

  always_comb begin
    state_d = state_q;
    if (launch)                               state_d = SQ_ISSUE;
    else if (ctrl_wr || own_hs)               state_d = SQ_IDLE;
    else if (state_q == SQ_ISSUE && req_hs)   state_d = SQ_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= SQ_IDLE;
      owed_q         <= '0;
      pend_q         <= 1'b0;
      stat_tout      <= 1'b0;
      stat_done      <= 1'b0;
      evt_launch     <= 1'b0;
      evt_abort      <= 1'b0;
      evt_end_cmd    <= 1'b0;
      evt_data_start <= 1'b0;
      req_index      <= '0;
      req_arg        <= '0;
    end else begin
      state_q        <= state_d;
      owed_q         <= owed_q + P_STALE_W'(orphan) - P_STALE_W'(drop_hs);
      evt_launch     <= launch;
      evt_abort      <= ctrl_wr;
      evt_end_cmd    <= own_hs && !ctrl_wr;
      evt_data_start <= resp_ok && cur_data_en;
      if (launch)       pend_q <= 1'b0;
      else if (ctrl_wr) pend_q <= 1'b1;
      if (launch) begin
        stat_tout <= 1'b0;
        stat_done <= 1'b0;
        req_index <= idx;
        req_arg   <= arg;
      end else begin
        if (resp_ok)  stat_done <= 1'b1;
        if (resp_bad) stat_tout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_issue_unit.sv
`timescale 1ns/1ps
module cmd_issue_unit
  import cmd_issue_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic                   clk_on,
  input  logic                   clk_start,
  output logic                   card_req_valid,
  input  logic                   card_req_ready,
  output logic [IDX_W-1:0]       card_req_index,
  output logic [ARG_W-1:0]       card_req_arg,
  input  logic                   card_rsp_valid,
  output logic                   card_rsp_ready,
  input  logic [LEN_W-1:0]       card_rsp_len,
  input  logic [RSP_BYTES*8-1:0] card_rsp_data,
  output logic                   evt_launch,
  output logic                   evt_abort,
  output logic                   evt_end_cmd,
  output logic                   evt_data_start,
  output logic                   stat_resp_tout,
  output logic                   stat_resp_done,
  output logic                   cmd_busy
);
  localparam int HALF_W = ARG_W / 2;

  logic [IDX_W-1:0]  idx;
  logic [ARG_W-1:0]  arg;
  logic [CTRL_W-1:0] ctrl, ctrl_new;
  logic              ctrl_wr, launch, resp_ok, fifo_pop;
  logic [15:0]       fifo_head;

  cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .idx(idx), .arg(arg), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .ctrl_new(ctrl_new)
  );

  cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .new_hold(ctrl_new[HOLD_BIT]), .cur_hold(ctrl[HOLD_BIT]),
    .cur_data_en(ctrl[DATA_EN_BIT]), .cur_rtype(ctrl[1:0]),
    .clk_on(clk_on), .clk_start(clk_start), .idx(idx), .arg(arg),
    .req_ready(card_req_ready), .rsp_valid(card_rsp_valid), .rsp_len(card_rsp_len),
    .req_valid(card_req_valid), .req_index(card_req_index), .req_arg(card_req_arg),
    .rsp_ready(card_rsp_ready), .launch(launch), .resp_ok(resp_ok),
    .evt_launch(evt_launch), .evt_abort(evt_abort), .evt_end_cmd(evt_end_cmd),
    .evt_data_start(evt_data_start), .stat_tout(stat_resp_tout),
    .stat_done(stat_resp_done), .busy(cmd_busy)
  );

  assign fifo_pop = reg_rd && (reg_addr == ADDR_W'(RA_RESP));

  resp_fifo u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(launch), .load(resp_ok),
    .load_len(card_rsp_len), .load_data(card_rsp_data),
    .pop(fifo_pop), .head(fifo_head)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(RA_CTRL): reg_rdata[CTRL_W-1:0] = ctrl;
      ADDR_W'(RA_IDX): begin
        reg_rdata[IDX_W-1:0] = idx;
        reg_rdata[IDX_W]     = 1'b1;
      end
      ADDR_W'(RA_ARGH): reg_rdata[HALF_W-1:0] = arg[ARG_W-1:HALF_W];
      ADDR_W'(RA_ARGL): reg_rdata[HALF_W-1:0] = arg[HALF_W-1:0];
      ADDR_W'(RA_RESP): reg_rdata = fifo_head;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmd_issue_chk.sv
`timescale 1ns/1ps
module cmd_issue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic        card_req_valid,
  input logic        card_req_ready,
  input logic [5:0]  card_req_index,
  input logic [31:0] card_req_arg,
  input logic        evt_launch,
  input logic        evt_abort,
  input logic        evt_end_cmd,
  input logic        evt_data_start,
  input logic        stat_resp_tout,
  input logic        stat_resp_done
);
  // R3
  abort_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0) |=> evt_abort);
  // R5
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_valid && !card_req_ready && !(reg_wr && reg_addr == 3'd0))
      |=> (card_req_valid && $stable(card_req_index) && $stable(card_req_arg)));
  // R5
  launch_offers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_launch |-> (card_req_valid && !stat_resp_tout && !stat_resp_done));
  // R6
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_resp_tout && stat_resp_done));
  // R7
  end_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end_cmd |-> (stat_resp_tout || stat_resp_done));
  // R10
  data_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_data_start |-> (evt_end_cmd && stat_resp_done));
endmodule

bind cmd_issue_unit cmd_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
  .card_req_index(card_req_index), .card_req_arg(card_req_arg),
  .evt_launch(evt_launch), .evt_abort(evt_abort), .evt_end_cmd(evt_end_cmd),
  .evt_data_start(evt_data_start), .stat_resp_tout(stat_resp_tout),
  .stat_resp_done(stat_resp_done)
);

// File: tb/cmd_issue_unit_tb.sv
`timescale 1ns/1ps
module cmd_issue_unit_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic reg_wr = 0, reg_rd = 0, clk_on = 0, clk_start = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic card_req_ready = 1, card_rsp_valid = 0;
  logic [4:0] card_rsp_len = 0;
  logic [127:0] card_rsp_data = '0;
  wire [15:0] reg_rdata;
  wire card_req_valid, card_rsp_ready;
  wire [5:0] card_req_index;
  wire [31:0] card_req_arg;
  wire evt_launch, evt_abort, evt_end_cmd, evt_data_start;
  wire stat_resp_tout, stat_resp_done, cmd_busy;

  cmd_issue_unit u_dut (.*);

  int vec = 0, miss = 0;
  task automatic chk(input string tag, input longint act, input longint exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // card model
  int cq_len[$], cq_tag[$];
  int cd = 0, lat = 2, nlen = 4, tagc = 1;

  // reference model
  int m_phase, m_stale, m_idx, m_argh, m_argl, m_ctrl, m_rptr, m_ridx;
  longint m_rarg;
  int m_fifo[9];
  bit m_pend, m_tout, m_done, m_ev_launch, m_ev_abort, m_ev_end, m_ev_data;

  always @(posedge clk) begin
    bit hsq, hsr, own, drop, cw, okc, lnch, pop;
    int mn, v;
    hsq = card_req_valid && card_req_ready;
    hsr = card_rsp_valid && card_rsp_ready;
    if (!rst_n) begin
      m_phase = 0; m_stale = 0; m_idx = 0; m_argh = 0; m_argl = 0; m_ctrl = 0;
      m_rptr = 0; m_ridx = 0; m_rarg = 0; m_pend = 0; m_tout = 0; m_done = 0;
      m_ev_launch = 0; m_ev_abort = 0; m_ev_end = 0; m_ev_data = 0;
      for (int i = 0; i < 9; i++) m_fifo[i] = 0;
      cq_len.delete(); cq_tag.delete(); cd = 0;
    end else begin
      if (hsr) begin void'(cq_len.pop_front()); void'(cq_tag.pop_front()); cd = lat; end
      else if (cd > 0) cd--;
      if (hsq) begin
        if (cq_len.size() == 0) cd = lat;
        cq_len.push_back(nlen); cq_tag.push_back(tagc); tagc++;
      end
      m_ev_launch = 0; m_ev_abort = 0; m_ev_end = 0; m_ev_data = 0;
      own  = hsr && m_phase == 2 && m_stale == 0;
      drop = hsr && m_stale > 0;
      cw   = reg_wr && reg_addr == 0;
      pop  = reg_rd && reg_addr == 4 && m_rptr < 9;
      okc = 0; lnch = 0;
      if (reg_wr && reg_addr == 1) m_idx = reg_wdata & 63;
      if (reg_wr && reg_addr == 2) m_argh = reg_wdata;
      if (reg_wr && reg_addr == 3) m_argl = reg_wdata;
      if (drop) m_stale--;
      if (cw) begin
        m_ctrl = reg_wdata & 'h3dff; m_pend = 1; m_ev_abort = 1;
        if ((m_phase == 2 && !own) || (m_phase == 1 && hsq)) m_stale++;
        lnch = clk_on && !reg_wdata[10];
        if (!lnch) m_phase = 0;
      end else if (own) begin
        mn = (m_ctrl & 3) == 0 ? 0 : ((m_ctrl & 3) == 2 ? 16 : 4);
        m_ev_end = 1; m_phase = 0;
        if (card_rsp_len >= mn) begin
          okc = 1; m_done = 1; m_rptr = 0; m_ev_data = m_ctrl[2];
          for (int i = 0; i < 9; i++) begin
            v = 0;
            if (2*i < card_rsp_len)   v |= card_rsp_data[16*i +: 8];
            if (2*i+1 < card_rsp_len) v |= card_rsp_data[16*i+8 +: 8] << 8;
            m_fifo[i] = v;
          end
        end else m_tout = 1;
      end else if (m_phase == 1 && hsq) m_phase = 2;
      else if (clk_start && m_pend && !m_ctrl[10]) lnch = 1;
      if (lnch) begin
        m_phase = 1; m_pend = 0; m_tout = 0; m_done = 0; m_ev_launch = 1;
        for (int i = 0; i < 9; i++) m_fifo[i] = 0;
        m_ridx = m_idx; m_rarg = (longint'(m_argh) << 16) | m_argl;
      end
      if (pop && !okc) m_rptr++;
    end
  end

  always @(negedge clk) begin
    #1;
    if (cq_len.size() > 0 && cd == 0) begin
      card_rsp_valid = 1;
      card_rsp_len = 5'(cq_len[0]);
      for (int j = 0; j < 16; j++) card_rsp_data[8*j +: 8] = 8'((cq_tag[0] * 16 + j + 7) & 255);
    end else card_rsp_valid = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 req_valid", card_req_valid, m_phase == 1);
      if (m_phase == 1) begin
        chk("R5 req_index", card_req_index, m_ridx);
        chk("R5 req_arg", card_req_arg, m_rarg);
      end
      chk("R11 rsp_ready", card_rsp_ready, (m_phase == 2) || (m_stale > 0));
      chk("R5 busy", cmd_busy, m_phase != 0);
      chk("R5 evt_launch", evt_launch, m_ev_launch);
      chk("R3 evt_abort", evt_abort, m_ev_abort);
      chk("R7 evt_end_cmd", evt_end_cmd, m_ev_end);
      chk("R10 evt_data_start", evt_data_start, m_ev_data);
      chk("R6 stat_resp_tout", stat_resp_tout, m_tout);
      chk("R10 stat_resp_done", stat_resp_done, m_done);
      if (reg_rd) case (reg_addr)
        0: chk("R3 ctrl read", reg_rdata, m_ctrl);
        1: chk("R1 index read", reg_rdata, m_idx | 64);
        2: chk("R2 arg high read", reg_rdata, m_argh);
        3: chk("R2 arg low read", reg_rdata, m_argl);
        4: chk("R8 R9 resp read", reg_rdata, m_rptr < 9 ? m_fifo[m_rptr] : 0);
        default: ;
      endcase
    end
  end

  task automatic put(input bit w, input bit r, input bit k, input int a, input int d);
    @(negedge clk); #1;
    reg_wr = w; reg_rd = r; clk_start = k; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk); #1;
    reg_wr = 0; reg_rd = 0; clk_start = 0;
  endtask
  task automatic wr(input int a, input int d); put(1, 0, 0, a, d); endtask
  task automatic rd(input int a); put(0, 1, 0, a, 0); endtask
  task automatic kick(); put(0, 0, 1, 0, 0); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic settle();
    for (int i = 0; i < 400 && (m_phase != 0 || m_stale != 0 || cq_len.size() != 0); i++)
      @(negedge clk);
    idle(2);
  endtask
  task automatic dump_resp(); for (int i = 0; i < 10; i++) rd(4); endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    int types[9] = '{1, 1, 2, 2, 3, 3, 0, 0, 1};
    int lens[9]  = '{4, 5, 16, 15, 3, 4, 0, 16, 0};
    int dens[9]  = '{0, 1, 0, 0, 0, 1, 1, 0, 0};
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12: reset state at the ports
    chk("R12 req_valid", card_req_valid, 0);
    chk("R12 status", {stat_resp_tout, stat_resp_done}, 0);
    chk("R12 events", {evt_launch, evt_abort, evt_end_cmd, evt_data_start}, 0);
    for (int a = 0; a < 5; a++) rd(a);
    // R1
    wr(1, 'h85); rd(1); wr(1, 'hffff); rd(1);
    // R2
    wr(2, 'habcd); wr(3, 'h1234); rd(2); rd(3); wr(3, 'h5678); rd(2); rd(3);
    // R3: masked value, hold bit set, clock off: no launch
    wr(0, 'hffff); rd(0); idle(3);
    // R4: hold bit blocks clk_start
    kick(); idle(3);
    // R4: pending released by clk_start
    nlen = 4; lat = 3; wr(1, 17); wr(0, 1); idle(3); kick(); settle(); dump_resp();
    // R4: no pending, clk_start ignored
    kick(); idle(4);
    // R6 R8 R10: response types and lengths with the clock running
    clk_on = 1;
    for (int t = 0; t < 9; t++) begin
      nlen = lens[t]; lat = 1 + t;
      wr(2, 'h1000 + t); wr(3, 'h0200 + t);
      wr(0, types[t] | (dens[t] << 2));
      settle(); dump_resp();
    end
    // R9: partial read then new completion resets the read position
    nlen = 16; wr(0, 2); settle(); rd(4); rd(4); rd(4);
    nlen = 6;  wr(0, 1); settle(); dump_resp();
    // R9: timeout keeps the exhausted read position
    nlen = 2;  wr(0, 1); settle(); rd(4);
    // R11: withdraw while waiting; late response discarded
    lat = 20; nlen = 4; wr(0, 1); idle(4); wr(0, 'h401); idle(3);
    nlen = 16; lat = 3; wr(1, 9); wr(0, 2); settle(); dump_resp();
    // R11: withdraw while the card stalls the request, then relaunch
    card_req_ready = 0; nlen = 4; wr(0, 1); idle(3); wr(1, 33); wr(0, 3); idle(2);
    card_req_ready = 1; settle(); dump_resp();
    // R11: withdraw and relaunch in one write while waiting
    lat = 15; nlen = 4; wr(0, 5); idle(5); nlen = 16; wr(0, 6); settle(); dump_resp();
    // R3 R4: hold bit with the clock running, then release by a plain write
    nlen = 4; lat = 2; wr(0, 'h401); idle(3); kick(); idle(3); wr(0, 1); settle(); dump_resp();
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule